// File: doc/BRIEF.md
# Prioritized Interrupt Vector Encoder

This block sits between the byte engine of a two-wire serial bus controller and the register interface that software reads. The engine raises one-cycle strobes for five kinds of event. The block keeps each event pending until software sees it. It does not show a status bitmap. It shows a single small code for the most urgent pending event. Reading that code removes exactly the event it named, so an interrupt routine only has to read the register repeatedly until it returns zero.

The block also holds the byte-to-word data path for a 16-bit data register that moves two bytes per access. A byte count is loaded at the start of a transfer. Received bytes are then gathered into words. Words written by software are handed to the engine one byte at a time. When the count is odd, the final access carries only one byte.

Top module: `i2c_irq_vector`

## Requirements
- R1: Code values are 0 nothing pending, 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. When several events are pending, the lowest code is shown, so arbitration lost outranks every other event.
- R2: A read strobe while the code is nonzero clears only the event being shown. The other events stay pending, and the code on the next cycle names the next one in priority order.
- R3: An event strobe in the same cycle as a read is kept. This holds even when it is the event being cleared.
- R4: The interrupt output is high exactly when the code is nonzero.
- R5: The vector read data is the code in bits 2:0, with every upper bit of the 16-bit word at zero.
- R6: A read strobe while the code is 0 changes nothing.
- R7: On receive, the first byte of each pair goes to bits 7:0 and the second to bits 15:8. The word is presented with a one-cycle valid pulse in the cycle after the second byte.
- R8: On receive with an odd count, the last byte is presented alone in bits 7:0 with bits 15:8 at zero, in the cycle after that byte.
- R9: On transmit, a written word is offered low byte (bits 7:0) first. The high byte (bits 15:8) is offered once the low byte is taken.
- R10: On transmit, when the byte just taken was the last of the count, the word is retired without offering its high byte.
- R11: After reset the code is 0, the interrupt is low, and no receive word or transmit byte is valid.
- R12: A received byte beyond the loaded count produces no word. A word write while a transmit word is still held leaves the offered byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_arb_lost | input | 1 | Arbitration-lost strobe |
| ev_no_ack | input | 1 | No-acknowledge strobe |
| ev_acc_rdy | input | 1 | Access-ready strobe |
| ev_rx_rdy | input | 1 | Receive-ready strobe |
| ev_tx_rdy | input | 1 | Transmit-ready strobe |
| vec_rd | input | 1 | Read strobe of the vector register |
| vec_code | output | 3 | Encoded highest-priority pending event |
| vec_rdata | output | 16 | Vector register read data |
| irq | output | 1 | Interrupt request |
| cnt_load | input | 1 | Load a new transfer byte count |
| cnt_val | input | 16 | Byte count to load |
| rx_bvalid | input | 1 | Received byte strobe from the engine |
| rx_byte | input | 8 | Received byte |
| rx_wvalid | output | 1 | Packed receive word valid pulse |
| rx_word | output | 16 | Packed receive word |
| tx_wr | input | 1 | Software write of a transmit word |
| tx_wdata | input | 16 | Transmit word |
| tx_take | input | 1 | Engine takes the offered byte |
| tx_bvalid | output | 1 | A transmit byte is offered |
| tx_byte | output | 8 | Offered transmit byte |

## Verification
The vector logic is first driven with all five events at once and then drained read by read. This separates a correct priority order from a reversed or partial one, and it shows whether a read clears one event or several. Read strobes on an empty vector, and reads that coincide with a fresh copy of the event being cleared, test whether pending state leaks or is lost. Long runs of seeded random event and read mixes are compared each cycle against a bench model of the pending set. Receive transfers with even and odd counts, plus a surplus byte, test the byte lane order, the half-filled last word and the count cutoff. Transmit runs of both parities test the byte order, the early retirement of the last word and the rejection of a second write.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
   localparam int NUM_EV = 5;
   localparam int CODE_W = $clog2(NUM_EV + 1);

   typedef enum logic [CODE_W-1:0] {
      VC_NONE = 3'd0,
      VC_ARB  = 3'd1,
      VC_NACK = 3'd2,
      VC_ACC  = 3'd3,
      VC_RX   = 3'd4,
      VC_TX   = 3'd5
   } vec_code_e;
endpackage

// File: rtl/ivec_prio.sv
// Lowest-index-wins encoder: bit i of pend maps to code i+1.
module ivec_prio #(
   parameter int N      = 5,
   parameter int CODE_W = 3
) (
   input  logic [N-1:0]      pend,
   output logic [CODE_W-1:0] code,
   output logic [N-1:0]      sel
);
   initial begin
      if (N >= (1 << CODE_W)) $error("ivec_prio: CODE_W too narrow for N");
   end

   always_comb begin
      code = '0;
      sel  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            code   = CODE_W'(i + 1);
            sel    = '0;
            sel[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ivec_pend.sv
// Pending-event store with read-to-clear of the reported event.
module ivec_pend #(
   parameter int N      = 5,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      ev,
   input  logic              rd,
   output logic [CODE_W-1:0] code,
   output logic              any
);
   logic [N-1:0] pend;
   logic [N-1:0] sel;

   ivec_prio #(.N(N), .CODE_W(CODE_W)) u_prio (
      .pend (pend),
      .code (code),
      .sel  (sel)
   );

   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[g] <= 1'b0;
         else        pend[g] <= (pend[g] & ~(rd & sel[g])) | ev[g];
      end
   end

   assign any = |pend;
endmodule

// File: rtl/ivec_rx_pack.sv
// Gathers received bytes into words, low lane first.
module ivec_rx_pack #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                acc,
   input  logic [BYTE_W-1:0]   bdata,
   input  logic                last,
   output logic                wvalid,
   output logic [2*BYTE_W-1:0] word
);
   logic              have_lo;
   logic [BYTE_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_lo <= 1'b0;
         lo_q    <= '0;
         wvalid  <= 1'b0;
         word    <= '0;
      end else begin
         wvalid <= 1'b0;
         if (flush) begin
            have_lo <= 1'b0;
         end else if (acc) begin
            if (have_lo) begin
               word    <= {bdata, lo_q};
               wvalid  <= 1'b1;
               have_lo <= 1'b0;
            end else if (last) begin
               word   <= {{BYTE_W{1'b0}}, bdata};
               wvalid <= 1'b1;
            end else begin
               lo_q    <= bdata;
               have_lo <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ivec_tx_unpack.sv
// Holds one software word and offers it byte by byte, low lane first.
module ivec_tx_unpack #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                wr,
   input  logic [2*BYTE_W-1:0] wdata,
   input  logic                can_load,
   input  logic                take,
   input  logic                last,
   output logic                bvalid,
   output logic [BYTE_W-1:0]   bdata
);
   logic [2*BYTE_W-1:0] word_q;
   logic                hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         hi_q   <= 1'b0;
         bvalid <= 1'b0;
      end else if (flush) begin
         hi_q   <= 1'b0;
         bvalid <= 1'b0;
      end else if (bvalid) begin
         if (take) begin
            if (!hi_q && !last) begin
               hi_q <= 1'b1;
            end else begin
               hi_q   <= 1'b0;
               bvalid <= 1'b0;
            end
         end
      end else if (wr && can_load) begin
         word_q <= wdata;
         hi_q   <= 1'b0;
         bvalid <= 1'b1;
      end
   end

   assign bdata = hi_q ? word_q[2*BYTE_W-1:BYTE_W] : word_q[BYTE_W-1:0];
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16,
   parameter int VEC_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ev_arb_lost,
   input  logic                      ev_no_ack,
   input  logic                      ev_acc_rdy,
   input  logic                      ev_rx_rdy,
   input  logic                      ev_tx_rdy,
   input  logic                      vec_rd,
   output logic [ivec_pkg::CODE_W-1:0] vec_code,
   output logic [VEC_W-1:0]          vec_rdata,
   output logic                      irq,
   input  logic                      cnt_load,
   input  logic [CNT_W-1:0]          cnt_val,
   input  logic                      rx_bvalid,
   input  logic [BYTE_W-1:0]         rx_byte,
   output logic                      rx_wvalid,
   output logic [2*BYTE_W-1:0]       rx_word,
   input  logic                      tx_wr,
   input  logic [2*BYTE_W-1:0]       tx_wdata,
   input  logic                      tx_take,
   output logic                      tx_bvalid,
   output logic [BYTE_W-1:0]         tx_byte
);
   import ivec_pkg::*;

   initial begin
      if (VEC_W < CODE_W) $error("i2c_irq_vector: VEC_W narrower than code");
      if (CNT_W < 2)      $error("i2c_irq_vector: CNT_W too small");
   end

   logic [NUM_EV-1:0] ev_vec;
   logic              any_pend;
   logic [CNT_W-1:0]  remain;
   logic              rx_acc;
   logic              tx_acc;
   logic              last_byte;

   assign ev_vec = {ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_no_ack, ev_arb_lost};

   ivec_pend #(.N(NUM_EV), .CODE_W(CODE_W)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev_vec),
      .rd    (vec_rd),
      .code  (vec_code),
      .any   (any_pend)
   );

   assign irq       = any_pend;
   assign vec_rdata = VEC_W'(vec_code);

   assign last_byte = (remain == CNT_W'(1));
   assign rx_acc    = rx_bvalid && (remain != '0);
   assign tx_acc    = tx_take && tx_bvalid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        remain <= '0;
      else if (cnt_load) remain <= cnt_val;
      else               remain <= remain - CNT_W'(rx_acc) - CNT_W'(tx_acc);
   end

   ivec_rx_pack #(.BYTE_W(BYTE_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (cnt_load),
      .acc    (rx_acc),
      .bdata  (rx_byte),
      .last   (last_byte),
      .wvalid (rx_wvalid),
      .word   (rx_word)
   );

   ivec_tx_unpack #(.BYTE_W(BYTE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (cnt_load),
      .wr       (tx_wr),
      .wdata    (tx_wdata),
      .can_load (remain != '0),
      .take     (tx_take),
      .last     (last_byte),
      .bvalid   (tx_bvalid),
      .bdata    (tx_byte)
   );
endmodule

// File: rtl/ivec_chk.sv
module ivec_chk #(
   parameter int BYTE_W = 8,
   parameter int VEC_W  = 16,
   parameter int CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_arb_lost,
   input logic              ev_no_ack,
   input logic              ev_acc_rdy,
   input logic              ev_rx_rdy,
   input logic              ev_tx_rdy,
   input logic              vec_rd,
   input logic [CODE_W-1:0] vec_code,
   input logic [VEC_W-1:0]  vec_rdata,
   input logic              irq,
   input logic              rx_bvalid,
   input logic              rx_wvalid,
   input logic              tx_wr,
   input logic              tx_take,
   input logic              tx_bvalid,
   input logic [BYTE_W-1:0] tx_byte
);
   logic [(1<<CODE_W)-1:0] evv;
   logic                   ev_any;
   assign evv    = (1 << CODE_W)'({ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_no_ack, ev_arb_lost, 1'b0});
   assign ev_any = |evv;

   a_r4_irq_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (vec_code != '0));

   a_r5_rdata_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rdata == VEC_W'(vec_code));

   a_r1_arb_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_arb_lost |=> vec_code == CODE_W'(1));

   a_r1_event_shows: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_any && !vec_rd) |=> vec_code != '0);

   a_r2_read_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && vec_code != '0 && !evv[vec_code]) |=> vec_code != $past(vec_code));

   a_r3_same_cycle_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && vec_code != '0 && evv[vec_code]) |=>
         (vec_code != '0 && vec_code <= $past(vec_code)));

   a_r6_empty_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && vec_code == '0 && !ev_any) |=> vec_code == '0);

   a_r7_word_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wvalid |-> $past(rx_bvalid));

   a_r12_held_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bvalid && tx_wr && !tx_take) |=> (tx_bvalid && $stable(tx_byte)));
endmodule

bind i2c_irq_vector ivec_chk #(.BYTE_W(BYTE_W), .VEC_W(VEC_W), .CODE_W(ivec_pkg::CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev_arb_lost (ev_arb_lost),
   .ev_no_ack   (ev_no_ack),
   .ev_acc_rdy  (ev_acc_rdy),
   .ev_rx_rdy   (ev_rx_rdy),
   .ev_tx_rdy   (ev_tx_rdy),
   .vec_rd      (vec_rd),
   .vec_code    (vec_code),
   .vec_rdata   (vec_rdata),
   .irq         (irq),
   .rx_bvalid   (rx_bvalid),
   .rx_wvalid   (rx_wvalid),
   .tx_wr       (tx_wr),
   .tx_take     (tx_take),
   .tx_bvalid   (tx_bvalid),
   .tx_byte     (tx_byte)
);

// File: tb/i2c_irq_vector_test.sv
module i2c_irq_vector_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_arb_lost = 0, ev_no_ack = 0, ev_acc_rdy = 0, ev_rx_rdy = 0, ev_tx_rdy = 0;
   logic        vec_rd = 0;
   logic [2:0]  vec_code;
   logic [15:0] vec_rdata;
   logic        irq;
   logic        cnt_load = 0;
   logic [15:0] cnt_val = 0;
   logic        rx_bvalid = 0;
   logic [7:0]  rx_byte = 0;
   logic        rx_wvalid;
   logic [15:0] rx_word;
   logic        tx_wr = 0;
   logic [15:0] tx_wdata = 0;
   logic        tx_take = 0;
   logic        tx_bvalid;
   logic [7:0]  tx_byte;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [4:0] mp = '0;

   i2c_irq_vector uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] model_code(input logic [4:0] p);
      for (int i = 0; i < 5; i++) if (p[i]) return 3'(i + 1);
      return 3'd0;
   endfunction

   function automatic logic [4:0] model_mask(input logic [4:0] p);
      logic [2:0] c = model_code(p);
      return (c == 0) ? 5'd0 : (5'd1 << (c - 1));
   endfunction

   // one vector-side cycle; inputs set at negedge, outputs checked next negedge
   task automatic vcycle(input logic [4:0] ev, input logic rd, input string tag);
      {ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_no_ack, ev_arb_lost} = ev;
      vec_rd = rd;
      @(posedge clk);
      mp = (mp & ~(rd ? model_mask(mp) : 5'd0)) | ev;
      @(negedge clk);
      {ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_no_ack, ev_arb_lost} = '0;
      vec_rd = 0;
      check({tag, " code"}, 32'(vec_code), 32'(model_code(mp)));
      check("R4 irq", 32'(irq), 32'(mp != 0));
      check("R5 rdata", 32'(vec_rdata), 32'(model_code(mp)));
   endtask

   task automatic load(input logic [15:0] n);
      cnt_load = 1; cnt_val = n;
      @(posedge clk); @(negedge clk);
      cnt_load = 0;
   endtask

   task automatic rx_send(input logic [7:0] b);
      rx_bvalid = 1; rx_byte = b;
      @(posedge clk); @(negedge clk);
      rx_bvalid = 0;
   endtask

   task automatic tx_step(input logic wr, input logic [15:0] wd, input logic take);
      tx_wr = wr; tx_wdata = wd; tx_take = take;
      @(posedge clk); @(negedge clk);
      tx_wr = 0; tx_take = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R11 reset state
      check("R11 code", 32'(vec_code), 0);
      check("R11 irq", 32'(irq), 0);
      check("R11 rx_wvalid", 32'(rx_wvalid), 0);
      check("R11 tx_bvalid", 32'(tx_bvalid), 0);

      // R1 all events at once, then R2 drain in priority order
      vcycle(5'b11111, 0, "R1 all pending");
      check("R1 arb first", 32'(vec_code), 1);
      for (int k = 2; k <= 5; k++) begin
         vcycle(5'b00000, 1, "R2 drain");
         check("R2 next code", 32'(vec_code), 32'(k));
      end
      vcycle(5'b00000, 1, "R2 last read");
      check("R2 empty", 32'(vec_code), 0);
      // R6 read on empty vector
      vcycle(5'b00000, 1, "R6 empty read");
      vcycle(5'b10000, 0, "R6 later event");
      check("R6 tx shows", 32'(vec_code), 5);
      // R3 same-cycle event of the cleared kind
      vcycle(5'b00000, 1, "R2 clear tx");
      vcycle(5'b00010, 0, "R1 nack");
      vcycle(5'b00010, 1, "R3 read plus nack");
      check("R3 nack kept", 32'(vec_code), 2);
      vcycle(5'b00100, 1, "R3 read plus acc");
      check("R3 acc kept", 32'(vec_code), 3);
      vcycle(5'b00000, 1, "R2 clear acc");

      // random mix against the model
      for (int n = 0; n < 800; n++) begin
         logic [4:0] ev;
         for (int b = 0; b < 5; b++) ev[b] = ($urandom % 5) == 0;
         vcycle(ev, ($urandom % 3) == 0, "R1 R2 R3 random");
      end

      // R7 R8 R12 receive, odd count 3
      load(16'd3);
      rx_send(8'hAA);
      check("R7 no word after one byte", 32'(rx_wvalid), 0);
      rx_send(8'hBB);
      check("R7 pair valid", 32'(rx_wvalid), 1);
      check("R7 pair word", 32'(rx_word), 32'h0000BBAA);
      rx_send(8'hCC);
      check("R8 odd valid", 32'(rx_wvalid), 1);
      check("R8 odd word", 32'(rx_word), 32'h000000CC);
      rx_send(8'hDD);
      check("R12 surplus byte", 32'(rx_wvalid), 0);

      // random receive transfers
      for (int t = 0; t < 20; t++) begin
         int len = 1 + ($urandom % 7);
         logic [7:0] lo = '0;
         load(16'(len));
         for (int i = 0; i < len; i++) begin
            logic [7:0] b = 8'($urandom);
            rx_send(b);
            if (i % 2 == 1) begin
               check("R7 rand valid", 32'(rx_wvalid), 1);
               check("R7 rand word", 32'(rx_word), 32'({b, lo}));
            end else if (i == len - 1) begin
               check("R8 rand valid", 32'(rx_wvalid), 1);
               check("R8 rand word", 32'(rx_word), 32'({8'h00, b}));
            end else begin
               check("R7 rand wait", 32'(rx_wvalid), 0);
            end
            lo = b;
         end
      end

      // R9 R10 R12 transmit, odd count 3
      load(16'd3);
      tx_step(1, 16'h2211, 0);
      check("R9 low valid", 32'(tx_bvalid), 1);
      check("R9 low byte", 32'(tx_byte), 32'h11);
      tx_step(1, 16'h9999, 0);
      check("R12 held byte", 32'(tx_byte), 32'h11);
      tx_step(0, 0, 1);
      check("R9 high valid", 32'(tx_bvalid), 1);
      check("R9 high byte", 32'(tx_byte), 32'h22);
      tx_step(0, 0, 1);
      check("R9 word retired", 32'(tx_bvalid), 0);
      tx_step(1, 16'h4433, 0);
      check("R10 last low byte", 32'(tx_byte), 32'h33);
      tx_step(0, 0, 1);
      check("R10 no high byte", 32'(tx_bvalid), 0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule